// File: doc/BRIEF.md
# DDR Data and Strobe Pin Drive Controller

This block sits between the command engine of a DDR memory controller and its pad cells. On every clock it decides whether the shared data bus and each byte-lane strobe pin are driven or left in high impedance. It also produces the values those pins carry. The command engine marks which cycles carry write data and which cycles are read-data windows, and supplies the write data and the strobe waveform sample for each write cycle.

Two bus-parking policies are offered, selected by a single rule input. In write-only mode the pins are released whenever no write data is moving. In drive-except-read mode the pins stay driven outside read windows. In that mode the data pins park on the most recently written word and the strobes park low, so that unterminated traces never float. Separately, a per-lane strobe enable can permanently silence any strobe pin. This serves single-strobe memories, where exactly one lane is enabled, and single-data-rate memories, where every lane is off.

Top module: `ddr_pin_drive_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the outputs at the next rising edge: the data output enable, every strobe output enable, the data output word and every strobe value become 0, and the stored data word becomes 0.
- R2: Every output is registered. The value after a rising edge depends only on the inputs sampled at that edge, and a change of input between edges leaves the outputs unchanged.
- R3: With the rule input at 0 (write-only mode), the data output enable is 1 exactly in the cycle after a write-data cycle and 0 otherwise.
- R4: With the rule input at 1 (drive-except-read mode), the data output enable is 0 exactly in the cycle after a read-data cycle and 1 otherwise.
- R5: A write-data cycle loads the write word into the stored word, which appears on the data output one cycle later. The data output keeps showing the last stored word (0 after reset) in every other cycle, whatever the mode.
- R6: Strobe pin n carries bit n of the strobe waveform input, one cycle after a write-data cycle on an enabled lane. In all other cases it carries 0, so parked strobes in drive-except-read mode are low.
- R7: The strobe output enable of lane n equals the lane-n bit of the strobe enable input ANDed with the data output enable rule of R3 and R4. The data enable is one signal for the whole bus, while the strobe enables are per lane.
- R8: A lane whose strobe enable bit is 0 never has its strobe output enable set, in either mode. With all four bits 0 (single data rate), no strobe pin is ever driven.
- R9: With exactly one strobe enable bit set (single-strobe memory), only that lane's strobe output enable can become 1.
- R10: Read and write indications are never high in the same cycle. When a read-data cycle directly follows a write-data cycle, the data and strobe enables fall in the output cycle that corresponds to the first read cycle, with no extra turnaround cycle. If both indications do arrive together, the read wins: nothing is driven and the stored word is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| drive_rule_i | input | 1 | 0 = drive only for writes, 1 = drive except during reads |
| lane_en_i | input | LANES | Per-lane strobe master enable |
| wr_cyc_i | input | 1 | Current cycle carries write data |
| rd_cyc_i | input | 1 | Current cycle is a read-data window |
| wdata_i | input | DATA_W | Write data for this cycle |
| strobe_wave_i | input | LANES | Strobe level to send per lane this cycle |
| data_oe_o | output | 1 | Output enable for the whole data bus |
| data_o | output | DATA_W | Value presented on the data pins |
| dqs_oe_o | output | LANES | Per-lane strobe output enable |
| dqs_o | output | LANES | Value presented on the strobe pins |

## Verification
The bench builds the block with its default 32-bit bus and four lanes, so each lane instance owns one byte of the stored word. With that width every single-lane enable pattern can be tried, as well as the all-off and mixed patterns. A behavioural model tracks the stored word and the expected pin states, and the outputs are compared with it in every cycle. The stimulus covers both parking modes, write-to-read turnaround, a switch of mode in mid-stream and a reset in mid-run after data has been stored.

// File: rtl/ddr_drv_pkg.sv
package ddr_drv_pkg;

  // Bus parking policy selected by the rule input.
  typedef enum logic {
    RULE_WRITE_ONLY  = 1'b0,
    RULE_EXCEPT_READ = 1'b1
  } drive_rule_e;

  // Per-cycle decision shared by the bus enable register and every lane.
  typedef struct packed {
    logic drive;  // pins should be driven in the next output cycle
    logic load;   // write data is accepted this cycle
  } pin_action_t;

endpackage

// File: rtl/ddr_drv_policy.sv
module ddr_drv_policy
  import ddr_drv_pkg::*;
(
  input  drive_rule_e rule_i,
  input  logic        wr_cyc_i,
  input  logic        rd_cyc_i,
  output pin_action_t act_o
);

  // A read window always wins over a write indication.
  logic write_ok;

  always_comb begin
    write_ok   = wr_cyc_i & ~rd_cyc_i;
    act_o.load = write_ok;
    unique case (rule_i)
      RULE_WRITE_ONLY:  act_o.drive = write_ok;
      RULE_EXCEPT_READ: act_o.drive = ~rd_cyc_i;
      default:          act_o.drive = 1'b0;
    endcase
  end

endmodule

// File: rtl/ddr_drv_bus_oe.sv
module ddr_drv_bus_oe
  import ddr_drv_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  pin_action_t act_i,
  output logic        data_oe_o
);

  always_ff @(posedge clk) begin
    if (rst) data_oe_o <= 1'b0;
    else     data_oe_o <= act_i.drive;
  end

endmodule

// File: rtl/ddr_drv_lane.sv
module ddr_drv_lane
  import ddr_drv_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  pin_action_t       act_i,
  input  logic              lane_en_i,
  input  logic [LANE_W-1:0] wdata_i,
  input  logic              wave_i,
  output logic [LANE_W-1:0] data_o,
  output logic              dqs_oe_o,
  output logic              dqs_o
);

  // The byte slice doubles as output register and parking hold register:
  // it only changes on an accepted write.
  logic [LANE_W-1:0] hold_q;
  logic              oe_q;
  logic              dqs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      oe_q   <= 1'b0;
      dqs_q  <= 1'b0;
    end else begin
      if (act_i.load) hold_q <= wdata_i;
      oe_q  <= lane_en_i & act_i.drive;
      dqs_q <= lane_en_i & act_i.load & wave_i;
    end
  end

  assign data_o   = hold_q;
  assign dqs_oe_o = oe_q;
  assign dqs_o    = dqs_q;

endmodule

// File: rtl/ddr_pin_drive_ctrl.sv
module ddr_pin_drive_ctrl
  import ddr_drv_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              drive_rule_i,
  input  logic [LANES-1:0]  lane_en_i,
  input  logic              wr_cyc_i,
  input  logic              rd_cyc_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  strobe_wave_i,
  output logic              data_oe_o,
  output logic [DATA_W-1:0] data_o,
  output logic [LANES-1:0]  dqs_oe_o,
  output logic [LANES-1:0]  dqs_o
);

  localparam int LANE_W = DATA_W / LANES;

  pin_action_t act;

  ddr_drv_policy policy_i (
    .rule_i   (drive_rule_e'(drive_rule_i)),
    .wr_cyc_i (wr_cyc_i),
    .rd_cyc_i (rd_cyc_i),
    .act_o    (act)
  );

  ddr_drv_bus_oe bus_oe_i (
    .clk       (clk),
    .rst       (rst),
    .act_i     (act),
    .data_oe_o (data_oe_o)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ddr_drv_lane #(.LANE_W(LANE_W)) lane_i (
      .clk       (clk),
      .rst       (rst),
      .act_i     (act),
      .lane_en_i (lane_en_i[g]),
      .wdata_i   (wdata_i[g*LANE_W +: LANE_W]),
      .wave_i    (strobe_wave_i[g]),
      .data_o    (data_o[g*LANE_W +: LANE_W]),
      .dqs_oe_o  (dqs_oe_o[g]),
      .dqs_o     (dqs_o[g])
    );
  end

endmodule

// File: rtl/ddr_pin_drive_ctrl_chk.sv
module ddr_pin_drive_ctrl_chk #(
  parameter int DATA_W = 32,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              drive_rule_i,
  input logic [LANES-1:0]  lane_en_i,
  input logic              wr_cyc_i,
  input logic              rd_cyc_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [LANES-1:0]  strobe_wave_i,
  input logic              data_oe_o,
  input logic [DATA_W-1:0] data_o,
  input logic [LANES-1:0]  dqs_oe_o,
  input logic [LANES-1:0]  dqs_o
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!data_oe_o && dqs_oe_o == '0 && data_o == '0 && dqs_o == '0));

  assert_write_only_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (!drive_rule_i && !wr_cyc_i) |=> !data_oe_o);

  assert_write_only_drive_R3: assert property (@(posedge clk) disable iff (rst)
    (!drive_rule_i && wr_cyc_i && !rd_cyc_i) |=> data_oe_o);

  assert_except_read_park_R4: assert property (@(posedge clk) disable iff (rst)
    (drive_rule_i && !rd_cyc_i) |=> data_oe_o);

  assert_read_release_R4: assert property (@(posedge clk) disable iff (rst)
    rd_cyc_i |=> !data_oe_o);

  assert_data_capture_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_cyc_i && !rd_cyc_i) |=> (data_o == $past(wdata_i)));

  assert_data_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !wr_cyc_i |=> $stable(data_o));

  assert_strobe_idle_low_R6: assert property (@(posedge clk) disable iff (rst)
    !wr_cyc_i |=> (dqs_o == '0));

  assert_lanes_follow_bus_R7: assert property (@(posedge clk) disable iff (rst)
    (lane_en_i == '1) |=> (dqs_oe_o == {LANES{data_oe_o}}));

  assert_lane_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (lane_en_i != '1) |=> ((dqs_oe_o & ~$past(lane_en_i)) == '0));

  assert_single_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    ($countones(lane_en_i) == 1) |=> $onehot0(dqs_oe_o));

  assert_no_rd_wr_overlap_R10: assert property (@(posedge clk) disable iff (rst)
    !(wr_cyc_i && rd_cyc_i));

  assert_turnaround_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_cyc_i && $past(wr_cyc_i)) |=> (!data_oe_o && dqs_oe_o == '0));

endmodule

bind ddr_pin_drive_ctrl ddr_pin_drive_ctrl_chk #(
  .DATA_W (DATA_W),
  .LANES  (LANES)
) chk_i (
  .clk           (clk),
  .rst           (rst),
  .drive_rule_i  (drive_rule_i),
  .lane_en_i     (lane_en_i),
  .wr_cyc_i      (wr_cyc_i),
  .rd_cyc_i      (rd_cyc_i),
  .wdata_i       (wdata_i),
  .strobe_wave_i (strobe_wave_i),
  .data_oe_o     (data_oe_o),
  .data_o        (data_o),
  .dqs_oe_o      (dqs_oe_o),
  .dqs_o         (dqs_o)
);

// File: tb/ddr_pin_drive_ctrl_tb_top.sv
`timescale 1ns/1ps
module ddr_pin_drive_ctrl_tb_top;

  localparam int DW = 32;
  localparam int NL = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          rule;
  logic [NL-1:0] en;
  logic          wr, rd;
  logic [DW-1:0] wd;
  logic [NL-1:0] wv;
  logic          data_oe;
  logic [DW-1:0] data;
  logic [NL-1:0] dqs_oe, dqs;

  always #4 clk = ~clk;  // 125 MHz

  ddr_pin_drive_ctrl #(.DATA_W(DW), .LANES(NL)) dut_i (
    .clk(clk), .rst(rst), .drive_rule_i(rule), .lane_en_i(en),
    .wr_cyc_i(wr), .rd_cyc_i(rd), .wdata_i(wd), .strobe_wave_i(wv),
    .data_oe_o(data_oe), .data_o(data), .dqs_oe_o(dqs_oe), .dqs_o(dqs)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // Reference model state
  logic          m_oe;
  logic [DW-1:0] m_hold;
  logic [NL-1:0] m_dqs_oe, m_dqs;
  bit            prev_wr;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive at the falling edge, check after the next falling edge.
  task automatic cycle(input bit r, input bit ru, input logic [NL-1:0] e,
                       input bit w, input bit rdx, input logic [DW-1:0] d,
                       input logic [NL-1:0] s);
    bit drv, ld, turn;
    string ltag;
    rst = r; rule = ru; en = e; wr = w; rd = rdx; wd = d; wv = s;
    #1;
    // R2: input change between edges must not reach the outputs
    chk("R2 data between edges", 64'(data), 64'(m_hold));
    chk("R2 oe between edges", 64'(data_oe), 64'(m_oe));
    turn = prev_wr && rdx && !r;
    if (r) begin
      m_oe = 0; m_hold = '0; m_dqs_oe = '0; m_dqs = '0;
    end else begin
      ld  = w && !rdx;
      drv = ru ? !rdx : ld;
      if (ld) m_hold = d;
      m_oe     = drv;
      m_dqs_oe = e & {NL{drv}};
      m_dqs    = ld ? (e & s) : '0;
    end
    prev_wr = w && !r;
    @(posedge clk);
    @(negedge clk);
    if (r) begin
      chk("R1 data_oe", 64'(data_oe), 0);
      chk("R1 data", 64'(data), 0);
      chk("R1 dqs_oe", 64'(dqs_oe), 0);
      chk("R1 dqs", 64'(dqs), 0);
    end else begin
      if (turn) chk("R10 turnaround data_oe", 64'(data_oe), 64'(m_oe));
      else if (ru) chk("R4 data_oe", 64'(data_oe), 64'(m_oe));
      else chk("R3 data_oe", 64'(data_oe), 64'(m_oe));
      chk("R5 data", 64'(data), 64'(m_hold));
      chk("R6 dqs", 64'(dqs), 64'(m_dqs));
      if (e == '0) ltag = "R8 dqs_oe";
      else if ($countones(e) == 1) ltag = "R9 dqs_oe";
      else ltag = "R7 dqs_oe";
      if (turn) ltag = "R10 turnaround dqs_oe";
      chk(ltag, 64'(dqs_oe), 64'(m_dqs_oe));
    end
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_oe = 0; m_hold = '0; m_dqs_oe = '0; m_dqs = '0; prev_wr = 0;
    rst = 1; rule = 0; en = '0; wr = 0; rd = 0; wd = '0; wv = '0;
    @(negedge clk);
    // R1: reset state
    cycle(1, 0, 4'hF, 0, 0, '0, '0);
    cycle(1, 1, 4'hF, 1, 0, 32'hDEAD_BEEF, 4'hF);
    // R3: write-only mode, writes, idle, read, write->read turnaround
    cycle(0, 0, 4'hF, 1, 0, 32'h1122_3344, 4'hF);
    cycle(0, 0, 4'hF, 1, 0, 32'h5566_7788, 4'h0);
    cycle(0, 0, 4'hF, 0, 0, 32'hFFFF_FFFF, 4'hF);
    cycle(0, 0, 4'hF, 0, 1, 32'h0BAD_0BAD, 4'hF);
    cycle(0, 0, 4'hF, 1, 0, 32'hA5A5_5A5A, 4'hA);
    cycle(0, 0, 4'hF, 0, 1, 32'h0, 4'h0);    // R10
    cycle(0, 0, 4'hF, 0, 0, 32'h0, 4'h0);
    // R4: drive-except-read, parked data held, strobes low
    cycle(0, 1, 4'hF, 0, 0, 32'h1234_5678, 4'hF);
    cycle(0, 1, 4'hF, 1, 0, 32'hCAFE_F00D, 4'h5);
    cycle(0, 1, 4'hF, 0, 1, 32'h0, 4'hF);    // R10 turnaround
    cycle(0, 1, 4'hF, 0, 1, 32'h0, 4'h0);
    cycle(0, 1, 4'hF, 0, 0, 32'h7777_7777, 4'hF);
    // R8: all strobes off (single data rate), both modes
    cycle(0, 1, 4'h0, 1, 0, 32'h0102_0304, 4'hF);
    cycle(0, 1, 4'h0, 0, 0, 32'h0, 4'h0);
    cycle(0, 0, 4'h0, 1, 0, 32'h0506_0708, 4'hF);
    // R9: each single lane in turn
    for (int k = 0; k < NL; k++) begin
      cycle(0, 0, NL'(1 << k), 1, 0, 32'h1111_1111 * (k + 1), 4'hF);
      cycle(0, 1, NL'(1 << k), 0, 0, 32'h0, 4'hF);
      cycle(0, 1, NL'(1 << k), 0, 1, 32'h0, 4'hF);
    end
    // R1: reset in mid-run clears the stored word
    cycle(0, 1, 4'hF, 1, 0, 32'h9999_AAAA, 4'hF);
    cycle(1, 1, 4'hF, 0, 0, 32'h0, 4'h0);
    cycle(0, 1, 4'hF, 0, 0, 32'h0, 4'h0);
    // Pseudo-random traffic with mode and lane changes, no overlap
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [NL-1:0] le;
      op = int'($urandom % 4);
      le = ((i / 50) % 3 == 0) ? 4'hF : NL'($urandom);
      cycle(0, ((i / 37) % 2) == 1, le, op == 1 || op == 3, op == 2,
            $urandom, NL'($urandom));
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule